// File: doc/BRIEF.md
# Indexed Register-Access Slave on a Two-Wire Serial Bus

The block is a serial-bus slave that gives an external host read and write access to a small file of 8-bit registers addressed by an 8-bit index. The clock and data pad levels are brought into the system clock domain through two-flop synchronizers. Each line then passes a filter that accepts a new level only after it has held steady for a set number of system clocks. The bus start, repeated start and stop conditions are decoded from the filtered levels.

The 7-bit slave address is one of four fixed values, picked by a 2-bit identity input. A write transfer carries the register index first and then any number of data bytes. To read, the host writes the index, issues a repeated start and addresses the slave with the read bit set. The slave then returns bytes from consecutive indices until the host declines a byte. The index advances by one after every data byte in either direction. Holding the power-down input low clears the register file and returns the slave to idle. The data line is driven open-drain only: the block outputs an enable that pulls the line low.

Top module: `i2c_reg_slave`

## Requirements
- R1: While `pwrDownN` is low, every register reads back 0x00, `sdaOe` is 0 and the slave is idle.
- R2: The slave address is 0x3C for `idSel`=00, 0x3D for 01, 0x36 for 10 and 0x37 for 11. The address byte carries the address in bits 7:1 and the read flag in bit 0 (1 = read).
- R3: On an address match the slave pulls SDA low in the acknowledge bit. On a mismatch it leaves SDA released and ignores the rest of the transfer until the next START.
- R4: In a write, the first byte after the address loads the index. Each later byte is stored at the index and acknowledged, and then the index increments by one.
- R5: After a repeated START with the read flag set, the slave sends bytes from successive indices MSB first, incrementing the index after each byte. A host NACK ends the read and leaves SDA released.
- R6: Writes to an index at or above `REG_DEPTH` (16 by default) are dropped, and reads from such an index return 0x00. The index wraps from 0xFF to 0x00.
- R7: A START or STOP in the middle of a byte abandons the transfer. Nothing of the partial byte is stored, and a following START is served normally.
- R8: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks (8 by default) is ignored.
- R9: `sdaOe` is asserted only while SCL is low. SDA is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| pwrDownN | input | 1 | Active-low power-down; clears all state while low |
| idSel | input | 2 | Selects one of four slave addresses |
| sclIn | input | 1 | Level on the serial clock pad |
| sdaIn | input | 1 | Level on the serial data pad |
| sdaOe | output | 1 | 1 pulls the data pad low; 0 releases it |

## Verification
Multi-byte writes followed by repeated-start reads show that storage and the index increment agree in both directions. Single reads ending in a NACK show that the slave releases the line when the host declines. All four identity settings are tried with the matching address and with a wrong one, which tells the address table apart from a constant match. A write to a wrong address followed by a read-back shows that the rest of an unmatched transfer is ignored. Transfers that cross index 0x0F/0x10 and 0xFF/0x00 exercise the range limit and the wrap. A STOP and a START inserted mid-byte, and 5-clock SCL spikes inserted during each high phase, separate correct abort and filter behaviour from designs that count stray edges as bits.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  typedef struct packed {
    logic shiftEn;   // sample one bit into the shift register
    logic idxLoad;   // load index from received byte
    logic regWrite;  // store received byte, advance index
    logic rdLoad;    // load read byte into shifter, advance index
  } dpStrobe_t;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [1:0] syncQ;
  logic [CW-1:0] cnt;
  logic levelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      cnt    <= '0;
      level  <= 1'b1;
      levelQ <= 1'b1;
    end else begin
      syncQ  <= {syncQ[0], pinIn};
      levelQ <= level;
      if (syncQ[1] == level) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        level <= syncQ[1];
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rise = level & ~levelQ;
  assign fall = ~level & levelQ;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] idSel,
  input  logic       sclLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLevel,
  input  logic       sdaRise,
  input  logic       sdaFall,
  input  logic [7:0] shiftByte,
  input  logic [7:0] rdByte,
  output dpStrobe_t  strobe,
  output logic       sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INDEX, S_WRITE, S_READ} state_t;

  state_t     state;
  logic [3:0] bitCnt;
  logic       inAck, readMode, hostNack;
  logic [6:0] myAddr;

  always_comb begin
    case (idSel)
      2'b00:   myAddr = 7'h3C;
      2'b01:   myAddr = 7'h3D;
      2'b10:   myAddr = 7'h36;
      default: myAddr = 7'h37;
    endcase
  end

  logic startDet, stopDet, active, byteDone, ackEnd, addrHit;
  assign startDet = sdaFall & sclLevel;
  assign stopDet  = sdaRise & sclLevel;
  assign active   = (state != S_IDLE) & ~startDet & ~stopDet;
  assign byteDone = active & sclFall & ~inAck & (bitCnt == 4'd8);
  assign ackEnd   = active & sclFall & inAck;
  assign addrHit  = (shiftByte[7:1] == myAddr);

  always_comb begin
    strobe.shiftEn  = active & sclRise & ~inAck & (bitCnt != 4'd8);
    strobe.idxLoad  = byteDone & (state == S_INDEX);
    strobe.regWrite = byteDone & (state == S_WRITE);
    strobe.rdLoad   = ackEnd & (((state == S_ADDR) & readMode) |
                                ((state == S_READ) & ~hostNack));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      inAck    <= 1'b0;
      readMode <= 1'b0;
      hostNack <= 1'b0;
      sdaOe    <= 1'b0;
    end else if (startDet) begin
      state  <= S_ADDR;
      bitCnt <= '0;
      inAck  <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      inAck  <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (state != S_IDLE) begin
      if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
      if (state == S_READ && sclFall && !inAck && bitCnt != 4'd8 && bitCnt != 4'd0)
        sdaOe <= ~shiftByte[7];
      if (inAck && sclRise && state == S_READ) hostNack <= sdaLevel;
      if (byteDone) begin
        inAck <= 1'b1;
        case (state)
          S_ADDR: begin
            if (addrHit) begin
              sdaOe    <= 1'b1;
              readMode <= shiftByte[0];
            end else begin
              state <= S_IDLE;
            end
          end
          S_READ:  sdaOe <= 1'b0;
          default: sdaOe <= 1'b1;
        endcase
      end
      if (ackEnd) begin
        inAck  <= 1'b0;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
        case (state)
          S_ADDR: begin
            state <= readMode ? S_READ : S_INDEX;
            if (readMode) sdaOe <= ~rdByte[7];
          end
          S_INDEX: state <= S_WRITE;
          S_READ: begin
            if (hostNack) state <= S_IDLE;
            else          sdaOe <= ~rdByte[7];
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_slave_pkg::*;
#(
  parameter int REG_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       sdaLevel,
  output logic [7:0] shiftByte,
  output logic [7:0] rdByte,
  output logic [7:0] index
);
  localparam int IDX_BITS = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1;
  localparam logic [8:0] DEPTH9 = 9'(REG_DEPTH);

  logic [7:0] regs [REG_DEPTH];
  logic       inRange;

  assign inRange = ({1'b0, index} < DEPTH9);
  assign rdByte  = inRange ? regs[index[IDX_BITS-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regs[i] <= 8'h00;
      shiftByte <= 8'h00;
      index     <= 8'h00;
    end else begin
      if (strobe.shiftEn) shiftByte <= {shiftByte[6:0], sdaLevel};
      if (strobe.idxLoad) index <= shiftByte;
      if (strobe.regWrite) begin
        if (inRange) regs[index[IDX_BITS-1:0]] <= shiftByte;
        index <= index + 8'd1;
      end
      if (strobe.rdLoad) begin
        shiftByte <= rdByte;
        index     <= index + 8'd1;
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int FILT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       pwrDownN,
  input  logic [1:0] idSel,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe
);
  logic sclLevel, sclRise, sclFall, sdaLevel, sdaRise, sdaFall;
  logic [7:0] shiftByte, rdByte, index;
  dpStrobe_t strobe;

  i2c_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_sclFilt (
    .clk(clk), .rstN(pwrDownN), .pinIn(sclIn),
    .level(sclLevel), .rise(sclRise), .fall(sclFall));

  i2c_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_sdaFilt (
    .clk(clk), .rstN(pwrDownN), .pinIn(sdaIn),
    .level(sdaLevel), .rise(sdaRise), .fall(sdaFall));

  i2c_slave_ctrl u_ctrl (
    .clk(clk), .rstN(pwrDownN), .idSel(idSel),
    .sclLevel(sclLevel), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLevel(sdaLevel), .sdaRise(sdaRise), .sdaFall(sdaFall),
    .shiftByte(shiftByte), .rdByte(rdByte),
    .strobe(strobe), .sdaOe(sdaOe));

  i2c_slave_dp #(.REG_DEPTH(REG_DEPTH)) u_dp (
    .clk(clk), .rstN(pwrDownN), .strobe(strobe), .sdaLevel(sdaLevel),
    .shiftByte(shiftByte), .rdByte(rdByte), .index(index));
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_slave_pkg::*;
(
  input logic       clk,
  input logic       pwrDownN,
  input logic       sclLevel,
  input logic       sdaRise,
  input logic       sdaOe,
  input dpStrobe_t  strobe,
  input logic [7:0] index
);
  // R9: the line is pulled low only while the filtered clock is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!pwrDownN)
    $rose(sdaOe) |-> !sclLevel);

  // R7: a stop condition leaves the line released
  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!pwrDownN)
    (sdaRise && sclLevel) |=> !sdaOe);

  // R4: a stored write byte advances the index by one
  a_r4_write_advances: assert property (@(posedge clk) disable iff (!pwrDownN)
    strobe.regWrite |=> index == $past(index) + 8'd1);

  // R5: each byte loaded for reading advances the index by one
  a_r5_read_advances: assert property (@(posedge clk) disable iff (!pwrDownN)
    strobe.rdLoad |=> index == $past(index) + 8'd1);

  // R4: loading the index and storing data never happen together
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!pwrDownN)
    $countones({strobe.idxLoad, strobe.regWrite, strobe.rdLoad}) <= 1);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk(clk), .pwrDownN(pwrDownN), .sclLevel(sclLevel), .sdaRise(sdaRise),
  .sdaOe(sdaOe), .strobe(strobe), .index(index));

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int Q = 24;

  logic clk = 1'b0;
  logic pwrDownN = 1'b0;
  logic [1:0] idSel = 2'b00;
  logic sclPin = 1'b1, sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic glitchOn = 1'b0;
  logic [6:0] curAddr = 7'h3C;
  int checks = 0, fails = 0, r9Bad = 0;
  logic oePrev = 1'b0;

  assign sdaLine = sdaM & ~sdaOe;

  always #4 clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .pwrDownN(pwrDownN), .idSel(idSel),
    .sclIn(sclPin), .sdaIn(sdaLine), .sdaOe(sdaOe));

  always @(negedge clk) begin
    if (sdaOe && !oePrev && sclPin) r9Bad++;
    oePrev <= sdaOe;
  end

  function automatic logic [6:0] tabAddr(input int i);
    case (i)
      0: return 7'h3C;
      1: return 7'h3D;
      2: return 7'h36;
      default: return 7'h37;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b0; waitq(); sclPin = 1'b0; waitq();
  endtask

  task automatic busRestart();
    sdaM = 1'b1; waitq(); sclPin = 1'b1; waitq();
    sdaM = 1'b0; waitq(); sclPin = 1'b0; waitq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitq(); sclPin = 1'b1; waitq(); sdaM = 1'b1; waitq();
  endtask

  task automatic sendBit(input logic b, output logic s);
    sdaM = b; waitq(); sclPin = 1'b1;
    repeat (Q/2) @(negedge clk);
    if (glitchOn) begin
      sclPin = 1'b0; repeat (5) @(negedge clk); sclPin = 1'b1;
    end
    repeat (Q/2) @(negedge clk);
    s = sdaLine; waitq(); sclPin = 1'b0; waitq();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(d[i], s);
    sendBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sendBit(1'b1, s);
      d[i] = s;
    end
    sendBit(~mAck, s);
  endtask

  task automatic wrRegs(input logic [7:0] idx, input logic [7:0] a, input logic [7:0] b,
                        input bit two);
    logic ack;
    busStart();
    sendByte({curAddr, 1'b0}, ack);
    sendByte(idx, ack);
    sendByte(a, ack);
    if (two) sendByte(b, ack);
    busStop();
  endtask

  task automatic rdRegs(input logic [7:0] idx, output logic [7:0] a, output logic [7:0] b);
    logic ack;
    busStart();
    sendByte({curAddr, 1'b0}, ack);
    sendByte(idx, ack);
    busRestart();
    sendByte({curAddr, 1'b1}, ack);
    recvByte(1'b1, a);
    recvByte(1'b0, b);
    busStop();
  endtask

  task automatic testReset();
    logic [7:0] a, b;
    chk("R1 sdaOe after reset", int'(sdaOe), 0);
    rdRegs(8'h00, a, b);
    chk("R1 reg0 after reset", int'(a), 0);
    chk("R1 reg1 after reset", int'(b), 0);
  endtask

  task automatic testWriteRead();
    logic [7:0] a, b;
    logic ack;
    busStart();
    sendByte({curAddr, 1'b0}, ack);
    chk("R3 ack on match", int'(ack), 1);
    sendByte(8'h02, ack);
    sendByte(8'hA5, ack);
    chk("R4 data ack", int'(ack), 1);
    sendByte(8'h3C, ack);
    sendByte(8'h96, ack);
    busStop();
    rdRegs(8'h02, a, b);
    chk("R4 reg2", int'(a), 'hA5);
    chk("R5 reg3 auto-index", int'(b), 'h3C);
    rdRegs(8'h04, a, b);
    chk("R4 reg4 third byte", int'(a), 'h96);
  endtask

  task automatic testIdTable();
    logic ack;
    for (int i = 0; i < 4; i++) begin
      idSel = 2'(i);
      busStart();
      sendByte({tabAddr(i), 1'b0}, ack);
      busStop();
      chk($sformatf("R2 ack for idSel=%0d", i), int'(ack), 1);
      busStart();
      sendByte({tabAddr((i + 1) % 4), 1'b0}, ack);
      busStop();
      chk($sformatf("R3 nack wrong addr idSel=%0d", i), int'(ack), 0);
    end
    idSel = 2'b00;
  endtask

  task automatic testMismatchIgnored();
    logic ack;
    logic [7:0] a, b;
    busStart();
    sendByte({7'h50, 1'b0}, ack);
    sendByte(8'h02, ack);
    sendByte(8'hFF, ack);
    busStop();
    chk("R3 no ack after mismatch", int'(ack), 0);
    rdRegs(8'h02, a, b);
    chk("R3 reg2 untouched", int'(a), 'hA5);
  endtask

  task automatic testReadNack();
    logic ack;
    logic [7:0] a;
    busStart();
    sendByte({curAddr, 1'b0}, ack);
    sendByte(8'h03, ack);
    busRestart();
    sendByte({curAddr, 1'b1}, ack);
    recvByte(1'b0, a);
    waitq();
    chk("R5 single read", int'(a), 'h3C);
    chk("R5 released after nack", int'(sdaOe), 0);
    busStop();
  endtask

  task automatic testRange();
    logic [7:0] a, b;
    wrRegs(8'h0F, 8'h11, 8'h22, 1'b1);
    rdRegs(8'h0F, a, b);
    chk("R6 reg15", int'(a), 'h11);
    chk("R6 index 16 reads zero", int'(b), 0);
    wrRegs(8'hFF, 8'h33, 8'h44, 1'b1);
    rdRegs(8'h00, a, b);
    chk("R6 wrap 0xFF to 0x00", int'(a), 'h44);
  endtask

  task automatic testAbort();
    logic ack, s;
    logic [7:0] a, b;
    busStart();
    sendByte({curAddr, 1'b0}, ack);
    sendByte(8'h05, ack);
    for (int i = 0; i < 3; i++) sendBit(1'b1, s);
    busStop();
    busStart();
    sendByte({curAddr, 1'b0}, ack);
    sendByte(8'h06, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1, s);
    busRestart();
    sendByte({curAddr, 1'b0}, ack);
    chk("R7 served after mid-byte start", int'(ack), 1);
    sendByte(8'h07, ack);
    sendByte(8'h77, ack);
    busStop();
    rdRegs(8'h05, a, b);
    chk("R7 reg5 after mid-byte stop", int'(a), 0);
    chk("R7 reg6 after mid-byte start", int'(b), 0);
    rdRegs(8'h07, a, b);
    chk("R7 reg7 written after abort", int'(a), 'h77);
  endtask

  task automatic testGlitch();
    logic [7:0] a, b;
    glitchOn = 1'b1;
    wrRegs(8'h08, 8'h5A, 8'h00, 1'b0);
    glitchOn = 1'b0;
    rdRegs(8'h08, a, b);
    chk("R8 reg8 despite scl spikes", int'(a), 'h5A);
    chk("R8 reg9 untouched", int'(b), 0);
  endtask

  task automatic testPowerDown();
    logic [7:0] a, b;
    pwrDownN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sdaOe in power-down", int'(sdaOe), 0);
    pwrDownN = 1'b1;
    repeat (3) @(negedge clk);
    rdRegs(8'h02, a, b);
    chk("R1 reg2 cleared", int'(a), 0);
    chk("R1 reg3 cleared", int'(b), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    pwrDownN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWriteRead();
    testIdTable();
    testMismatchIgnored();
    testReadNack();
    testRange();
    testAbort();
    testGlitch();
    testPowerDown();
    chk("R9 drive only while scl low", r9Bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule